// File: doc/BRIEF.md
# Move-Wide Immediate Builder

This execution unit assembles a wide constant inside a destination register one 16-bit lane at a time. Because a fixed 32-bit instruction cannot hold a full 64-bit literal, software issues one clearing insert followed by up to three merging inserts. Each insert names a 16-bit immediate, a lane position, an operation and a width.

For each request the unit takes the destination's current value and returns the new value with a valid strobe and a write-enable. The clearing form places the immediate and zeroes every other bit. The merging form places the immediate and keeps every other bit of the old value. In 32-bit width mode the upper half of the result is forced to zero, and only lane positions 0 and 1 are accepted. A request at position 2 or 3 in that mode is flagged illegal and never writes.

Top module: `wide_imm_builder`

## Requirements
- R1: With `in_op`=0 (clear-insert) in 64-bit mode (`in_w32`=0), the result holds the immediate in the selected lane and zero in all other bits.
- R2: With `in_op`=1 (keep-insert) in 64-bit mode, the result holds the immediate in the selected lane and the bits of `in_old` everywhere else.
- R3: Lane position k (0..3 on `in_pos`) places the immediate at result bits [16k+15:16k].
- R4: With `in_w32`=1 and a legal position, bits [63:32] of the result are zero for both operations. A keep-insert still keeps the other lane of the low half from `in_old`.
- R5: With `in_w32`=1 and `in_pos` equal to 2 or 3, `out_illegal` is 1, `out_wen` is 0 and `out_data` is zero.
- R6: `out_valid` is `in_valid` delayed by exactly one clock. `out_wen` is 1 only when `out_valid` is 1 and the request was legal. `out_illegal` is 0 whenever `out_valid` is 0.
- R7: In a cycle after `in_valid` was 0, `out_data` keeps its previous value and `out_valid`, `out_wen` and `out_illegal` are 0.
- R8: While reset is asserted and after its release, before any request, `out_valid`, `out_wen` and `out_illegal` are 0 and `out_data` is zero.
- R9: One clear-insert followed by three keep-inserts at the remaining positions, each fed the previous result, yields any chosen 64-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_op | input | 1 | 0 = clear-insert, 1 = keep-insert |
| in_imm | input | 16 | Immediate lane value |
| in_pos | input | 2 | Lane position (shift = 16 × position) |
| in_w32 | input | 1 | 1 = 32-bit width mode |
| in_old | input | 64 | Current destination value |
| out_valid | output | 1 | Result present |
| out_wen | output | 1 | Write the result to the destination |
| out_illegal | output | 1 | Request had an illegal position for its width |
| out_data | output | 64 | Result value |

## Verification
Every combination of operation, lane position and width is swept against several old-value patterns: all zeros, all ones, alternating bits and a distinct value per lane. The all-ones and distinct per-lane old values reveal a lane that leaks through or that is kept in the wrong place. Immediates of all ones and of asymmetric bit patterns reveal a wrong shift or a swapped byte. Four-step build sequences toward several target constants show that results chain correctly. Idle cycles between requests show that the outputs hold their value and the strobes drop.

// File: rtl/wib_pkg.sv
package wib_pkg;
  typedef enum logic {
    WIB_OP_CLEAR = 1'b0,
    WIB_OP_KEEP  = 1'b1
  } wib_op_e;
endpackage

// File: rtl/wib_lane_sel.sv
module wib_lane_sel #(
  parameter int NLANES = 4,
  parameter int POS_W  = 2
) (
  input  logic [POS_W-1:0]  pos,
  input  logic              w32,
  output logic [NLANES-1:0] sel,
  output logic              illegal
);
  localparam int HALF = NLANES / 2;

  for (genvar i = 0; i < NLANES; i++) begin : g_dec
    assign sel[i] = (pos == POS_W'(i));
  end

  // Narrow mode accepts only the lanes of the low half.
  assign illegal = w32 && (int'(pos) >= HALF);

  always_comb begin
    assert ($onehot0(sel)) else $error("lane select not one-hot");
  end
endmodule

// File: rtl/wib_lane_merge.sv
module wib_lane_merge
  import wib_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LANE_W = 16,
  parameter int NLANES = XLEN / LANE_W
) (
  input  wib_op_e           op,
  input  logic [LANE_W-1:0] imm,
  input  logic [NLANES-1:0] sel,
  input  logic              w32,
  input  logic [XLEN-1:0]   old_val,
  output logic [XLEN-1:0]   merged
);
  localparam int HALF = NLANES / 2;

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    logic [LANE_W-1:0] kept;
    logic [LANE_W-1:0] lane_val;
    assign kept = (op == WIB_OP_KEEP) ? old_val[i*LANE_W +: LANE_W] : '0;
    always_comb begin
      lane_val = sel[i] ? imm : kept;
      if (i >= HALF && w32) lane_val = '0;
    end
    assign merged[i*LANE_W +: LANE_W] = lane_val;
  end
endmodule

// File: rtl/wide_imm_builder.sv
module wide_imm_builder
  import wib_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_op,
  input  logic [15:0]       in_imm,
  input  logic [1:0]        in_pos,
  input  logic              in_w32,
  input  logic [63:0]       in_old,
  output logic              out_valid,
  output logic              out_wen,
  output logic              out_illegal,
  output logic [63:0]       out_data
);
  localparam int NLANES = XLEN / LANE_W;
  localparam int POS_W  = $clog2(NLANES);
  localparam int HALF_W = XLEN / 2;

  logic [NLANES-1:0] sel;
  logic              illegal_c;
  logic [XLEN-1:0]   merged;
  wib_op_e           op_c;

  assign op_c = wib_op_e'(in_op);

  wib_lane_sel #(.NLANES(NLANES), .POS_W(POS_W)) u_sel (
    .pos     (in_pos),
    .w32     (in_w32),
    .sel     (sel),
    .illegal (illegal_c)
  );

  wib_lane_merge #(.XLEN(XLEN), .LANE_W(LANE_W), .NLANES(NLANES)) u_merge (
    .op      (op_c),
    .imm     (in_imm),
    .sel     (sel),
    .w32     (in_w32),
    .old_val (in_old),
    .merged  (merged)
  );

  // Next-state logic
  logic            valid_d, wen_d, ill_d, data_en;
  logic [XLEN-1:0] data_d;

  always_comb begin
    valid_d = in_valid;
    ill_d   = in_valid && illegal_c;
    wen_d   = in_valid && !illegal_c;
    data_en = in_valid;
    data_d  = illegal_c ? '0 : merged;
  end

  // State registers
  logic            valid_q, wen_q, ill_q;
  logic [XLEN-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      wen_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      wen_q   <= wen_d;
      ill_q   <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_wen     = wen_q;
  assign out_illegal = ill_q;
  assign out_data    = data_q;

  // Assertions
  p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_wen && !out_illegal));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  p_no_wen_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (!out_wen && out_data == '0));
  p_flag_illegal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_w32 && in_pos[1]) |=> (out_illegal && !out_wen));
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_w32) |=> (out_data[XLEN-1:HALF_W] == '0));
  p_imm_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_w32) |=> (out_data[int'($past(in_pos))*LANE_W +: LANE_W] == $past(in_imm)));
endmodule

// File: tb/sim_wide_imm_builder.sv
`timescale 1ns/1ps
module sim_wide_imm_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_op = 1'b0;
  logic [15:0] in_imm = '0;
  logic [1:0]  in_pos = '0;
  logic        in_w32 = 1'b0;
  logic [63:0] in_old = '0;
  logic        out_valid, out_wen, out_illegal;
  logic [63:0] out_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  wide_imm_builder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_imm(in_imm), .in_pos(in_pos), .in_w32(in_w32), .in_old(in_old),
    .out_valid(out_valid), .out_wen(out_wen), .out_illegal(out_illegal),
    .out_data(out_data)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic op, input logic [15:0] imm,
      input logic [1:0] pos, input logic w32, input logic [63:0] old);
    logic [63:0] mask, res;
    if (w32 && pos >= 2) return 64'd0;
    mask = 64'hFFFF << (16 * pos);
    res  = (op ? old : 64'd0) & ~mask;
    res  = res | (64'(imm) << (16 * pos));
    if (w32) res[63:32] = '0;
    return res;
  endfunction

  // Issue one request, check the registered result and the following idle cycle.
  task automatic issue(input logic op, input logic [15:0] imm, input logic [1:0] pos,
      input logic w32, input logic [63:0] old, output logic [63:0] res);
    logic [63:0] exp;
    logic        ill;
    string       tag;
    exp = model(op, imm, pos, w32, old);
    ill = w32 && pos >= 2;
    if (ill) tag = "R5";
    else if (w32) tag = "R4";
    else if (op) tag = "R2/R3";
    else tag = "R1/R3";
    in_valid = 1'b1; in_op = op; in_imm = imm; in_pos = pos; in_w32 = w32; in_old = old;
    @(negedge clk);
    in_valid = 1'b0; in_imm = ~imm; in_old = ~old; in_op = ~op;
    check({tag, " data"}, out_data, exp);
    check("R6 valid", 64'(out_valid), 64'd1);
    check("R6 wen", 64'(out_wen), 64'(!ill));
    check("R5 illegal", 64'(out_illegal), 64'(ill));
    @(negedge clk);
    check("R7 hold data", out_data, exp);
    check("R7 strobes idle", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    res = out_data;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] olds [4];
    logic [15:0] imms [4];
    logic [63:0] targets [3];
    logic [63:0] r;
    olds[0] = 64'h0; olds[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    olds[2] = 64'hAAAA_5555_AAAA_5555; olds[3] = 64'h4444_3333_2222_1111;
    imms[0] = 16'hFFFF; imms[1] = 16'h0001; imms[2] = 16'h8000; imms[3] = 16'hC3A5;
    targets[0] = 64'h0123_4567_89AB_CDEF;
    targets[1] = 64'hFFFF_0000_FFFF_0000;
    targets[2] = 64'h8000_0000_0000_0001;

    repeat (3) @(negedge clk);
    check("R8 reset data", out_data, 64'd0);
    check("R8 reset strobes", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", {61'd0, out_valid, out_wen, out_illegal}, 64'd0);
    check("R8 data after release", out_data, 64'd0);

    for (int w = 0; w < 2; w++)
      for (int o = 0; o < 2; o++)
        for (int p = 0; p < 4; p++)
          for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
              issue(o[0], imms[b], p[1:0], w[0], olds[a], r);

    // R9: one clear-insert then three keep-inserts, chained.
    for (int t = 0; t < 3; t++) begin
      issue(1'b0, targets[t][15:0], 2'd0, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, r);
      for (int k = 1; k < 4; k++)
        issue(1'b1, targets[t][16*k +: 16], 2'(k), 1'b0, r, r);
      check("R9 built constant", r, targets[t]);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule